// File: doc/BRIEF.md
# Pipelined Seed-and-Refine Reciprocal Unit

This block returns the reciprocal of a normalized fixed-point mantissa x, where 1 ≤ x < 2. Only the fraction bits of x enter the block; the integer one is implied. A small constant table, indexed by the top fraction bits, supplies a first estimate with a few guard bits beyond its index width. One Newton-Raphson refinement, y1 = y0·(2 − x·y0), then roughly squares the relative error of that estimate. Table contents are the rounded reciprocals of each index interval's midpoint. They are computed by a constant function when the design is elaborated.

The datapath is a fixed ten-register pipeline: one register after the table, four for the multiply x·y0, one for the subtraction from two, and four for the final multiply. A valid flag travels with each operand, so a new mantissa may enter on every cycle. Idle cycles pass through as idle output cycles. The result is a fraction in (0.5, 1] held in OUT_W bits. Results that round up to 1.0 saturate to all ones. Exponent handling and the quotient multiply belong to the surrounding divider.

Top module: `recip_nr`

## Requirements
- R1: An operand accepted with in_vld high is presented with out_vld high exactly 10 clock cycles later. Operands may be accepted on every cycle with no stall.
- R2: For every 16-bit mantissa m, with x = (65536 + m)/65536, the result r satisfies |r·(65536 + m) − 2^32| ≤ 65536 + m. This means r is within one unit of 2^-16 of 1/x.
- R3: Mantissa 0x0000 (x = 1.0) returns 0xFFFF rather than wrapping to zero.
- R4: Every result presented with out_vld high has bit 15 set, that is, it lies at or above 0x8000 (one half).
- R5: out_vld is low while rst_n is low, and stays low after reset until the first accepted operand reaches the output.
- R6: A cycle with in_vld low produces a cycle with out_vld low 10 cycles later. The spacing between results matches the spacing between operands.
- R7: While out_vld is low, out_recip keeps the value of the most recent result.
- R8: Mantissa 0xFFFF (x just below 2) returns exactly 0x8000.
- R9: The seed is selected by the top IDX_W fraction bits of the mantissa. The table entry for index i is 2^(IDX_W+GUARD_W+1) divided by the interval midpoint 1 + (i + 0.5)/2^IDX_W, rounded to nearest. This estimate keeps the correction term 2 − x·y0 within 2^-(IDX_W−1) of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operand on in_mant is valid this cycle |
| in_mant | input | FRAC_W (16) | Fraction bits of x; the leading one is implied |
| out_vld | output | 1 | Result on out_recip is valid this cycle |
| out_recip | output | OUT_W (16) | Reciprocal as an unsigned fraction in (0.5, 1], saturated to all ones |

## Verification
On every cycle, the assertions tie the count of in-flight operands to the valid pipeline. They also keep the Newton correction term inside its narrow window around one, keep every valid result in the upper half of the range, and hold the output steady during idle cycles. Only the bench's scenarios can show arithmetic accuracy. These include the exhaustive sweep of all mantissas, the saturation at x = 1.0, the exact value just below two, and the placement of results against gapped random traffic.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Register stages inside each pipelined multiplier.
  localparam int unsigned MUL_STAGES = 4;

  // Rounded reciprocal of the midpoint of interval idx, scaled by 2^seed_w.
  // Interval idx covers [1 + idx/2^k, 1 + (idx+1)/2^k).
  function automatic longint unsigned midpoint_recip(int unsigned idx,
                                                     int unsigned k,
                                                     int unsigned seed_w);
    longint unsigned num;
    longint unsigned den;
    num = 64'd1 << (seed_w + k + 1);
    den = (64'd1 << (k + 1)) + 64'(2 * idx + 1);
    return (2 * num + den) / (2 * den);
  endfunction

endpackage

// File: rtl/recip_seed_rom.sv
module recip_seed_rom
  import recip_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned GUARD_W = 3
) (
  input  logic [IDX_W-1:0]       idx,
  output logic [IDX_W+GUARD_W:0] seed
);

  localparam int unsigned ENT_W  = IDX_W + GUARD_W;
  localparam int unsigned SEED_W = ENT_W + 1;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  // Entries keep only the bits after the leading one, which is always set.
  logic [ENT_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam longint unsigned FULL = midpoint_recip(i, IDX_W, SEED_W);
    assign tbl[i] = ENT_W'(FULL - (64'd1 << ENT_W));
  end

  assign seed = {1'b1, tbl[idx]};

endmodule

// File: rtl/recip_mul_pipe.sv
module recip_mul_pipe
  import recip_pkg::*;
#(
  parameter int unsigned A_W = 17,
  parameter int unsigned B_W = 12
) (
  input  logic                  clk,
  input  logic [MUL_STAGES-1:0] stage_en,
  input  logic [A_W-1:0]        a,
  input  logic [B_W-1:0]        b,
  output logic [A_W+B_W-1:0]    prod
);

  localparam int unsigned SL_W = (B_W + 3) / 4;
  localparam int unsigned BP_W = 4 * SL_W;
  localparam int unsigned PP_W = A_W + SL_W;
  localparam int unsigned HF_W = A_W + 2 * SL_W + 1;
  localparam int unsigned SM_W = A_W + BP_W;
  localparam int unsigned PR_W = A_W + B_W;

  logic [BP_W-1:0] b_pad;
  logic [PP_W-1:0] pp_d [4];
  logic [PP_W-1:0] pp_q [4];
  logic [HF_W-1:0] hf_d [2];
  logic [HF_W-1:0] hf_q [2];
  logic [SM_W-1:0] sm_d;
  logic [SM_W-1:0] sm_q;
  logic [PR_W-1:0] pr_q;

  assign b_pad = BP_W'(b);

  // Stage 1 next state: one partial product per slice of b.
  for (genvar j = 0; j < 4; j++) begin : g_pp
    assign pp_d[j] = PP_W'(a) * PP_W'(b_pad[j*SL_W +: SL_W]);
  end

  // Stage 2 next state: pairwise merge of adjacent slices.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign hf_d[h] = HF_W'(pp_q[2*h]) + (HF_W'(pp_q[2*h+1]) << SL_W);
  end

  // Stage 3 next state: final merge.
  assign sm_d = SM_W'(hf_q[0]) + (SM_W'(hf_q[1]) << (2 * SL_W));

  always_ff @(posedge clk) begin
    if (stage_en[0]) pp_q <= pp_d;
    if (stage_en[1]) hf_q <= hf_d;
    if (stage_en[2]) sm_q <= sm_d;
    if (stage_en[3]) pr_q <= sm_q[PR_W-1:0];
  end

  assign prod = pr_q;

endmodule

// File: rtl/recip_nr.sv
module recip_nr
  import recip_pkg::*;
#(
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned GUARD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [FRAC_W-1:0] in_mant,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_recip
);

  localparam int unsigned SEED_W = IDX_W + GUARD_W + 1;
  localparam int unsigned X_W    = FRAC_W + 1;
  localparam int unsigned PF     = FRAC_W + SEED_W;
  localparam int unsigned P_W    = X_W + SEED_W;
  localparam int unsigned T_W    = PF + 2;
  localparam int unsigned Y_W    = T_W + SEED_W;
  localparam int unsigned SH     = SEED_W + PF - OUT_W;
  localparam int unsigned Q_W    = Y_W + 1 - SH;
  localparam int unsigned LAT    = 2 * MUL_STAGES + 2;
  localparam int unsigned OCC_W  = $clog2(LAT + 1);
  localparam logic [T_W-1:0] CORR_ONE = T_W'(1) << PF;
  localparam logic [T_W-1:0] CORR_TOL = T_W'(1) << (PF - IDX_W + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // Valid pipeline; bit n marks data held after register n+1.
  logic [LAT-1:0] vld_d;
  logic [LAT-1:0] vld_q;

  assign vld_d = {vld_q[LAT-2:0], in_vld};

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) vld_q <= '0;
    else          vld_q <= vld_d;
  end

  // Register 1: seed lookup.
  logic [SEED_W-1:0] seed_w;
  logic [X_W-1:0]    x_q;
  logic [SEED_W-1:0] s_q;

  recip_seed_rom #(
    .IDX_W   (IDX_W),
    .GUARD_W (GUARD_W)
  ) u_seed_rom (
    .idx  (in_mant[FRAC_W-1 -: IDX_W]),
    .seed (seed_w)
  );

  always_ff @(posedge clk) begin
    if (in_vld) begin
      x_q <= {1'b1, in_mant};
      s_q <= seed_w;
    end
  end

  // Registers 2..5: x * y0, with the seed delayed alongside.
  logic [P_W-1:0]    p_w;
  logic [SEED_W-1:0] s_dl [MUL_STAGES];

  recip_mul_pipe #(
    .A_W (X_W),
    .B_W (SEED_W)
  ) u_mul_xy (
    .clk      (clk),
    .stage_en (vld_q[MUL_STAGES-1:0]),
    .a        (x_q),
    .b        (s_q),
    .prod     (p_w)
  );

  always_ff @(posedge clk) begin
    if (vld_q[0]) s_dl[0] <= s_q;
    for (int j = 1; j < MUL_STAGES; j++) begin
      if (vld_q[j]) s_dl[j] <= s_dl[j-1];
    end
  end

  // Register 6: correction term 2 - x*y0.
  logic [T_W-1:0]    t_d;
  logic [T_W-1:0]    t_q;
  logic [SEED_W-1:0] st_q;

  assign t_d = (T_W'(1) << (PF + 1)) - T_W'(p_w);

  always_ff @(posedge clk) begin
    if (vld_q[MUL_STAGES]) begin
      t_q  <= t_d;
      st_q <= s_dl[MUL_STAGES-1];
    end
  end

  // Registers 7..10: y0 * (2 - x*y0).
  logic [Y_W-1:0] y_w;

  recip_mul_pipe #(
    .A_W (T_W),
    .B_W (SEED_W)
  ) u_mul_ty (
    .clk      (clk),
    .stage_en (vld_q[2*MUL_STAGES:MUL_STAGES+1]),
    .a        (t_q),
    .b        (st_q),
    .prod     (y_w)
  );

  // Round to nearest, then clamp a result of 1.0 to all ones.
  logic [Y_W:0]   y_rnd;
  logic [Q_W-1:0] q_w;
  logic           sat_w;

  always_comb begin
    y_rnd     = (Y_W+1)'(y_w) + ((Y_W+1)'(1) << (SH - 1));
    q_w       = Q_W'(y_rnd >> SH);
    sat_w     = |q_w[Q_W-1:OUT_W];
    out_recip = sat_w ? '1 : q_w[OUT_W-1:0];
  end

  assign out_vld = vld_q[LAT-1];

  // Occupancy count kept only for checking.
  logic [OCC_W-1:0] occ_d;
  logic [OCC_W-1:0] occ_q;

  assign occ_d = occ_q + OCC_W'(in_vld) - OCC_W'(out_vld);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) occ_q <= '0;
    else          occ_q <= occ_d;
  end

  // R1
  lat_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(vld_q) == int'(occ_q));

  // R9
  corr_window_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    vld_q[MUL_STAGES+1] |-> (t_q > CORR_ONE - CORR_TOL) && (t_q < CORR_ONE + CORR_TOL));

  // R4
  range_floor_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_vld |-> out_recip[OUT_W-1]);

  // R4
  result_known_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_vld |-> !$isunknown(out_recip));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !out_vld |-> $stable(out_recip));

endmodule

// File: tb/recip_nr_bench.sv
`timescale 1ns/1ps
module recip_nr_bench;

  localparam int FW  = 16;
  localparam int OW  = 16;
  localparam int LAT = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [FW-1:0] in_mant = '0;
  logic          out_vld;
  logic [OW-1:0] out_recip;

  always #4 clk = ~clk;

  recip_nr u_recip_nr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_mant   (in_mant),
    .out_vld   (out_vld),
    .out_recip (out_recip)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int due_q[$];
  int mant_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint nearest(int m);
    longint x;
    longint r;
    x = (longint'(1) << FW) + longint'(m);
    r = ((longint'(1) << (FW + OW + 1)) + x) / (2 * x);
    if (r > (longint'(1) << OW) - 1) r = (longint'(1) << OW) - 1;
    return r;
  endfunction

  function automatic bit within_ulp(int m, int o);
    longint x;
    longint d;
    x = (longint'(1) << FW) + longint'(m);
    d = longint'(o) * x - (longint'(1) << (FW + OW));
    if (d < 0) d = -d;
    return d <= x;
  endfunction

  task automatic note_fail(string req, longint act, longint exp);
    fails++;
    $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
  endtask

  task automatic send(bit v, int m);
    @(negedge clk);
    in_vld  = v;
    in_mant = FW'(m);
    if (v) begin
      due_q.push_back(cyc + LAT);
      mant_q.push_back(m);
    end
  endtask

  // Output monitor: result slots against the operand schedule.
  always @(negedge clk) begin
    if (mon_en) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        int m;
        m = mant_q[0];
        void'(due_q.pop_front());
        void'(mant_q.pop_front());
        checks++;
        if (!out_vld) note_fail("R1 result missing", 0, 1);
        else begin
          checks++;
          if (!within_ulp(m, int'(out_recip))) note_fail("R2 accuracy", out_recip, nearest(m));
          checks++;
          if (!out_recip[OW-1]) note_fail("R4 range", out_recip, 32768);
          if (m == 0) begin
            checks++;
            if (out_recip != 16'hFFFF) note_fail("R3 saturation", out_recip, 65535);
          end
          if (m == 16'hFFFF) begin
            checks++;
            if (out_recip != 16'h8000) note_fail("R8 near two", out_recip, 32768);
          end
        end
      end else begin
        checks++;
        if (out_vld) note_fail("R6 unexpected valid", 1, 0);
      end
    end
  end

  initial begin
    int unsigned sd;
    logic [OW-1:0] held;
    sd = $urandom(32'd4177);
    // R5: reset state
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0) note_fail("R5 during reset", out_vld, 0);
    end
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0) note_fail("R5 after reset", out_vld, 0);
    end
    mon_en = 1'b1;

    // Directed corners: R3, R8, table boundaries.
    send(1, 0);
    send(1, 16'hFFFF);
    send(1, 1);
    send(1, 16'h8000);
    send(0, 0);
    send(1, 16'h0100);
    send(1, 16'h00FF);
    send(1, 16'h7FFF);
    send(0, 0);
    send(0, 0);
    send(1, 16'hFF00);

    // R2, R1: exhaustive back-to-back sweep.
    for (int m = 0; m < (1 << FW); m++) send(1, m);

    // R6: random operands with random gaps.
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      send((r % 3) != 0, int'(($urandom) & 32'h0000FFFF));
    end

    send(0, 0);
    repeat (LAT + 4) send(0, 0);

    // R7: output held while idle.
    @(negedge clk);
    held = out_recip;
    repeat (16) begin
      @(negedge clk);
      checks++;
      if (out_recip !== held) note_fail("R7 idle hold", out_recip, held);
    end
    checks++;
    if (due_q.size() != 0) note_fail("R1 results outstanding", due_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1440000;
    if (!done) begin
      checks++;
      note_fail("watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule